// File: doc/BRIEF.md
# Serial-In Block Write Port

This block is the write side of a sequential-access video memory. Samples arrive one per clock while a shift enable is high. They go into a chain of sixteen 12-bit stages, so the chain always holds the sixteen newest samples. A transfer strobe copies the whole chain into a holding latch in one clock. The chain keeps taking samples in that clock and in the clocks after it, so the input stream never has to pause.

The memory controller works on its own schedule. It raises a commit strobe together with a two-bit command code. Only the write code moves the latched block into the output register. That register drives a 192-bit parallel word to the memory array, together with a one-cycle commit pulse. Because the latch sits between the chain and the commit, the transfer strobe and the memory write slot are decoupled. A whole block can wait in the latch while the next block streams into the chain.

The command code uses these encodings: `2'b00` and `2'b01` are read commands for the other ports, `2'b10` is a write, and `2'b11` is a refresh. Reset is synchronous and active high.

Top module: `serial_block_port`

## Requirements
- R1: While `rst` is high at a rising clock edge, the shift chain, the holding latch, `wr_word` and `wr_valid` are all cleared to zero. A write commit issued right after reset therefore drives an all-zero word.
- R2: Every cycle with `shift_en` high captures `sample_in`. After sixteen captures, a transfer and a write commit place the first sample in `wr_word[11:0]` and the k-th sample (k = 1..16) in `wr_word[12k-1:12k-12]`, so the sixteenth lands in `[191:180]`.
- R3: When more than sixteen samples are shifted in before a transfer, only the sixteen most recent are kept. The oldest fall out of bits `[11:0]`.
- R4: A cycle with `xfer_stb` high copies the entire chain into the holding latch. In any cycle without `xfer_stb` the latch keeps its contents.
- R5: When `shift_en` and `xfer_stb` are high in the same cycle, the latch takes the chain contents from before that cycle's shift. The new sample stays in the chain for the next block.
- R6: A cycle with `commit_stb` high and `cmd_mode` equal to `2'b10` makes `wr_valid` high in the next cycle, with `wr_word` equal to the latch contents in the commit cycle.
- R7: A commit strobe with `cmd_mode` equal to `2'b00`, `2'b01` or `2'b11` is ignored: `wr_valid` stays low and `wr_word` is unchanged.
- R8: When `xfer_stb` and a write commit fall in the same cycle, `wr_word` receives the latch contents from before the transfer. The newly transferred block is delivered by the next write commit.
- R9: Samples shifted in after a transfer do not disturb the latched block. A commit issued many cycles later still delivers the block captured at the transfer.
- R10: `wr_word` holds its value in every cycle that has no write commit, and `wr_valid` is high only in the cycle after a write commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 12 | Incoming sample |
| shift_en | input | 1 | Capture `sample_in` into the chain this cycle |
| xfer_stb | input | 1 | Copy the chain into the holding latch |
| commit_stb | input | 1 | Memory controller command strobe |
| cmd_mode | input | 2 | Command code; `2'b10` is a write |
| wr_word | output | 192 | Parallel block presented to the memory array |
| wr_valid | output | 1 | One-cycle pulse after each accepted write commit |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a sample shift and a transfer: the latch must take the chain as it stood before the shift. The second pair is a transfer and a write commit: the output must take the latch as it stood before the transfer. Directed sequences raise both strobes of each pair in the same clock. Random traffic also hits these collisions often, because the three strobes are drawn independently. The bench keeps a sample-level model built from the requirements and compares `wr_word` and `wr_valid` after every clock, so a collision resolved the wrong way shows up as a wrong block at the next commit.

// File: rtl/sip_pkg.sv
package sip_pkg;

    localparam int unsigned DEF_LANES  = 16;
    localparam int unsigned DEF_SAMP_W = 12;
    localparam int unsigned DEF_WORD_W = DEF_LANES * DEF_SAMP_W;

    typedef enum logic [1:0] {
        CMD_READ_A  = 2'b00,
        CMD_READ_B  = 2'b01,
        CMD_WRITE   = 2'b10,
        CMD_REFRESH = 2'b11
    } cmd_e;

    typedef struct packed {
        logic stb;
        cmd_e code;
    } ctrl_cmd_t;

    function automatic logic is_write_commit(input ctrl_cmd_t c);
        return c.stb && (c.code == CMD_WRITE);
    endfunction

endpackage

// File: rtl/sip_shift_chain.sv
module sip_shift_chain #(
    parameter int unsigned LANES  = sip_pkg::DEF_LANES,
    parameter int unsigned SAMP_W = sip_pkg::DEF_SAMP_W,
    localparam int unsigned WORD_W = LANES * SAMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [SAMP_W-1:0] sample_in,
    output logic [WORD_W-1:0] chain_q
);

    // lane 0 holds the oldest sample; new samples enter at the top lane
    logic [SAMP_W-1:0] lane_q [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == LANES - 1) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst)           lane_q[i] <= '0;
                else if (shift_en) lane_q[i] <= sample_in;
            end
        end else begin : g_inner
            always_ff @(posedge clk) begin
                if (rst)           lane_q[i] <= '0;
                else if (shift_en) lane_q[i] <= lane_q[i+1];
            end
        end
        assign chain_q[i*SAMP_W +: SAMP_W] = lane_q[i];
    end

endmodule

// File: rtl/sip_hold_latch.sv
module sip_hold_latch #(
    parameter int unsigned WORD_W = sip_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/sip_commit_stage.sv
module sip_commit_stage #(
    parameter int unsigned WORD_W = sip_pkg::DEF_WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  sip_pkg::ctrl_cmd_t cmd,
    input  logic [WORD_W-1:0]  block_in,
    output logic [WORD_W-1:0]  word_q,
    output logic               valid_q
);

    logic take;
    assign take = sip_pkg::is_write_commit(cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) word_q <= block_in;
        end
    end

endmodule

// File: rtl/serial_block_port.sv
module serial_block_port (
    input  logic         clk,
    input  logic         rst,
    input  logic [11:0]  sample_in,
    input  logic         shift_en,
    input  logic         xfer_stb,
    input  logic         commit_stb,
    input  logic [1:0]   cmd_mode,
    output logic [191:0] wr_word,
    output logic         wr_valid
);
    import sip_pkg::*;

    localparam int unsigned LANES  = DEF_LANES;
    localparam int unsigned SAMP_W = DEF_SAMP_W;
    localparam int unsigned WORD_W = LANES * SAMP_W;

    logic [WORD_W-1:0] chain_q;
    logic [WORD_W-1:0] hold_q;
    ctrl_cmd_t         cmd;

    assign cmd.stb  = commit_stb;
    assign cmd.code = cmd_e'(cmd_mode);

    sip_shift_chain #(.LANES(LANES), .SAMP_W(SAMP_W)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .sample_in (sample_in),
        .chain_q   (chain_q)
    );

    sip_hold_latch #(.WORD_W(WORD_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (xfer_stb),
        .d    (chain_q),
        .q    (hold_q)
    );

    sip_commit_stage #(.WORD_W(WORD_W)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .block_in (hold_q),
        .word_q   (wr_word),
        .valid_q  (wr_valid)
    );

endmodule

// File: rtl/serial_block_port_checker.sv
module serial_block_port_checker (
    input logic         clk,
    input logic         rst,
    input logic [11:0]  sample_in,
    input logic         shift_en,
    input logic         xfer_stb,
    input logic         commit_stb,
    input logic [1:0]   cmd_mode,
    input logic [191:0] chain_q,
    input logic [191:0] hold_q,
    input logic [191:0] wr_word,
    input logic         wr_valid
);

    logic wr_cmd;
    assign wr_cmd = commit_stb && (cmd_mode == 2'b10);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (wr_word == '0 && !wr_valid && hold_q == '0 && chain_q == '0));

    // R2
    a_r2_entry_lane: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> chain_q[191:180] == $past(sample_in));

    // R3
    a_r3_oldest_drops: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> chain_q[179:0] == $past(chain_q[191:12]));

    // R5
    a_r5_pre_shift_copy: assert property (@(posedge clk) disable iff (rst)
        xfer_stb |=> hold_q == $past(chain_q));

    // R9
    a_r9_latch_kept: assert property (@(posedge clk) disable iff (rst)
        !xfer_stb |=> $stable(hold_q));

    // R6
    a_r6_commit_word: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> (wr_valid && wr_word == $past(hold_q)));

    // R7
    a_r7_other_modes: assert property (@(posedge clk) disable iff (rst)
        !wr_cmd |=> (!wr_valid && $stable(wr_word)));

endmodule

bind serial_block_port serial_block_port_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_in  (sample_in),
    .shift_en   (shift_en),
    .xfer_stb   (xfer_stb),
    .commit_stb (commit_stb),
    .cmd_mode   (cmd_mode),
    .chain_q    (chain_q),
    .hold_q     (hold_q),
    .wr_word    (wr_word),
    .wr_valid   (wr_valid)
);

// File: tb/serial_block_port_test.sv
module serial_block_port_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [11:0]  sample_in = '0;
    logic         shift_en = 1'b0;
    logic         xfer_stb = 1'b0;
    logic         commit_stb = 1'b0;
    logic [1:0]   cmd_mode = 2'b00;
    logic [191:0] wr_word;
    logic         wr_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [11:0]  m_chain [16];
    logic [191:0] m_hold;
    logic [191:0] m_word;
    logic         m_valid;

    always #10 clk = ~clk;

    serial_block_port uut (
        .clk(clk), .rst(rst), .sample_in(sample_in), .shift_en(shift_en),
        .xfer_stb(xfer_stb), .commit_stb(commit_stb), .cmd_mode(cmd_mode),
        .wr_word(wr_word), .wr_valid(wr_valid)
    );

    function automatic logic [191:0] pack_chain();
        logic [191:0] w;
        for (int i = 0; i < 16; i++) w[i*12 +: 12] = m_chain[i];
        return w;
    endfunction

    function automatic logic [11:0] pat(input int blk, input int k);
        return 12'((blk * 37 + k * 113 + 5) & 12'hfff);
    endfunction

    task automatic chk_word(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s wr_word act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s wr_valid act=%b exp=%b", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, compare after it
    task automatic step(input logic sh, input logic [11:0] smp, input logic xf,
                        input logic cm, input logic [1:0] md, input string req);
        logic wc;
        @(negedge clk);
        shift_en = sh; sample_in = smp; xfer_stb = xf; commit_stb = cm; cmd_mode = md;
        @(posedge clk);
        wc = cm && (md == 2'b10);
        m_valid = wc;
        if (wc) m_word = m_hold;
        if (xf) m_hold = pack_chain();
        if (sh) begin
            for (int i = 0; i < 15; i++) m_chain[i] = m_chain[i+1];
            m_chain[15] = smp;
        end
        #5;
        chk_bit(req, wr_valid, m_valid);
        chk_word(req, wr_word, m_word);
    endtask

    task automatic idle(input string req);
        step(1'b0, 12'h0, 1'b0, 1'b0, 2'b00, req);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [191:0] blk_a;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 16; i++) m_chain[i] = '0;
        m_hold = '0; m_word = '0; m_valid = 1'b0;

        // R1: reset with busy inputs
        rst = 1'b1;
        shift_en = 1'b1; sample_in = 12'hABC; xfer_stb = 1'b1; commit_stb = 1'b1; cmd_mode = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_word("R1", wr_word, '0);
        chk_bit("R1", wr_valid, 1'b0);
        rst = 1'b0; shift_en = 0; xfer_stb = 0; commit_stb = 0; cmd_mode = 0;
        step(1'b0, 12'h0, 1'b1, 1'b0, 2'b00, "R1");
        step(1'b0, 12'h0, 1'b0, 1'b1, 2'b10, "R1");

        // R2: sixteen samples, transfer, commit, lane positions
        for (int k = 0; k < 16; k++) step(1'b1, pat(1, k), 1'b0, 1'b0, 2'b00, "R2");
        step(1'b0, 12'h0, 1'b1, 1'b0, 2'b00, "R4");
        step(1'b0, 12'h0, 1'b0, 1'b1, 2'b10, "R6");
        checks++;
        if (wr_word[11:0] !== pat(1, 0) || wr_word[191:180] !== pat(1, 15)) begin
            failures++;
            $display("FAIL R2 ends act=%h/%h exp=%h/%h", wr_word[11:0], wr_word[191:180], pat(1,0), pat(1,15));
        end
        idle("R10");
        chk_bit("R10", wr_valid, 1'b0);

        // R3: twenty samples before transfer
        for (int k = 0; k < 20; k++) step(1'b1, pat(2, k), 1'b0, 1'b0, 2'b00, "R3");
        step(1'b0, 12'h0, 1'b1, 1'b0, 2'b00, "R3");
        step(1'b0, 12'h0, 1'b0, 1'b1, 2'b10, "R3");
        checks++;
        if (wr_word[11:0] !== pat(2, 4)) begin
            failures++;
            $display("FAIL R3 oldest act=%h exp=%h", wr_word[11:0], pat(2, 4));
        end

        // R5: shift and transfer in the same cycle
        for (int k = 0; k < 15; k++) step(1'b1, pat(3, k), 1'b0, 1'b0, 2'b00, "R5");
        step(1'b1, pat(3, 15), 1'b1, 1'b0, 2'b00, "R5");
        step(1'b0, 12'h0, 1'b0, 1'b1, 2'b10, "R5");
        checks++;
        if (wr_word[191:180] !== pat(3, 14)) begin
            failures++;
            $display("FAIL R5 top lane act=%h exp=%h", wr_word[191:180], pat(3, 14));
        end

        // R8: transfer and commit in the same cycle
        blk_a = m_hold;
        for (int k = 0; k < 16; k++) step(1'b1, pat(4, k), 1'b0, 1'b0, 2'b00, "R8");
        step(1'b0, 12'h0, 1'b1, 1'b1, 2'b10, "R8");
        chk_word("R8", wr_word, blk_a);
        step(1'b0, 12'h0, 1'b0, 1'b1, 2'b10, "R8");

        // R7: non-write command codes ignored
        for (int k = 0; k < 16; k++) step(1'b1, pat(5, k), 1'b0, 1'b0, 2'b00, "R7");
        step(1'b0, 12'h0, 1'b1, 1'b0, 2'b00, "R7");
        step(1'b0, 12'h0, 1'b0, 1'b1, 2'b00, "R7");
        chk_bit("R7", wr_valid, 1'b0);
        step(1'b0, 12'h0, 1'b0, 1'b1, 2'b01, "R7");
        step(1'b0, 12'h0, 1'b0, 1'b1, 2'b11, "R7");

        // R9: stream continues after transfer, late commit still returns block
        blk_a = m_hold;
        for (int k = 0; k < 40; k++) step(1'b1, pat(6, k), 1'b0, 1'b0, 2'b00, "R9");
        step(1'b0, 12'h0, 1'b0, 1'b1, 2'b10, "R9");
        chk_word("R9", wr_word, blk_a);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], 12'($urandom), (r[5:2] == 4'd0), (r[9:7] == 3'd0), r[11:10], "R4 R6 R10");
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule